// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is the control engine of one DMA channel. It runs either a single transfer described by four channel registers, or a chain of descriptors held in memory. A descriptor is four 32-bit words. In memory they sit at offsets 0, 4, 8 and 12 from the descriptor pointer, in this order: device address, memory address, size word and link word. The engine fetches descriptors through a simple read port. It drives a request/acknowledge handshake toward an external data mover, which moves one beat of data per acknowledge.

The size word carries a byte count and a width code. Each count is checked against a limit that depends on the width, and a bad size word ends the channel with an error pulse. The two low bits of the link word select two things for each descriptor: whether the chain goes on, and whether finishing that descriptor raises a done pulse. A 2-bit state output shows whether the engine is idle, reading a descriptor, waiting between beats or accessing. Setting the mode to disable stops the channel at the next beat boundary.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the state output is 0 (idle), neither request output is raised, and `done_o` and `err_o` are low.
- R2: The state codes are 0 idle, 1 descriptor read, 2 waiting and 3 accessing. The mode codes are 0 disable, 1 chain and 2 one-shot. A start strobe in idle with mode 2 loads the four channel registers directly and goes to waiting with no descriptor read.
- R3: Bits 13:12 of the size word select the beat width: code 3 is 1 byte, 2 is 2 bytes and 0 is 4 bytes. Bits 11:0 give the count in bytes. Each acknowledged beat adds the width to the memory address and takes the width off the count, so a descriptor moves ceil(count/width) beats.
- R4: With `dir_i`=1 the source is the memory address and the destination is the device address. With `dir_i`=0 the two are swapped. The device address stays the same for every beat of a descriptor. `dir_i` is held steady while the channel is busy.
- R5: A start strobe in idle with mode 1 sets the pointer to `reg_next_i` with bits 1:0 cleared. The engine then reads four words at pointer+0, +4, +8 and +12 with state 1, and after that runs the descriptor.
- R6: Bit 1 of the link word means follow: in chain mode the engine then fetches the next descriptor from the link word with bits 1:0 cleared. In one-shot mode the channel always ends after its one descriptor.
- R7: When a descriptor finishes with bit 0 of its link word set, `done_o` pulses for exactly one cycle. No done pulse is raised for a descriptor whose bit 0 is clear.
- R8: A width code of 1, or a count above 0x3FF for the 1-byte and 2-byte widths, or a count above 0x7FF for the 4-byte width, gives a one-cycle `err_o` pulse. The engine is then idle and no beat is moved.
- R9: A start strobe while the engine is not idle is ignored.
- R10: Mode 0 while busy makes the engine finish any beat already requested and then return to idle, with no done pulse.
- R11: A raised `mrd_req_o` or `xfer_req_o` is held, with its address outputs unchanged, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe |
| mode_i | input | 2 | 0 disable, 1 chain, 2 one-shot |
| dir_i | input | 1 | 1 memory to device, 0 device to memory |
| reg_dev_i | input | 32 | Channel device-address register |
| reg_mem_i | input | 32 | Channel memory-address register |
| reg_size_i | input | 14 | Channel size register (width code and count) |
| reg_next_i | input | 32 | Channel link register |
| mrd_req_o | output | 1 | Descriptor read request |
| mrd_addr_o | output | 32 | Descriptor word address |
| mrd_ack_i | input | 1 | Read acknowledge, data valid |
| mrd_data_i | input | 32 | Read data |
| xfer_req_o | output | 1 | Beat request to the data mover |
| xfer_src_o | output | 32 | Beat source address |
| xfer_dst_o | output | 32 | Beat destination address |
| xfer_width_o | output | 3 | Beat width in bytes (1, 2 or 4) |
| xfer_ack_i | input | 1 | Beat acknowledge |
| state_o | output | 2 | Engine state |
| done_o | output | 1 | Descriptor-finished pulse |
| err_o | output | 1 | Bad size word pulse |

## Verification
One-shot transfers are run at each of the three widths and in both directions. These runs separate the address stepping from the count stepping, and the source from the destination routing. Two-descriptor chains are run with the link codes follow-without-done followed by end-with-done, and then follow-with-done followed by end-without-done. Comparing the beat totals with the done counts shows that continuation and the done pulse are decoded from separate bits. A one-shot run whose link word has follow set shows that chaining is tied to the mode. Size words exactly at each limit and one past it separate an off-by-one limit check from a correct one. A stalled data mover is used to land a second start and a disable in the middle of a transfer.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DESC   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_ACCESS = 2'd3
  } dcs_state_e;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_CHAIN = 2'd1;
  localparam logic [1:0] MODE_ONCE  = 2'd2;
endpackage

// File: rtl/dcs_size_chk.sv
module dcs_size_chk #(
  parameter int CNT_W      = 12,
  parameter int WSEL_LSB   = 12,
  parameter int LIM_NARROW = 'h3FF,
  parameter int LIM_WIDE   = 'h7FF
) (
  input  logic [WSEL_LSB+1:0] size_i,
  output logic                valid_o,
  output logic [2:0]          width_o,
  output logic [CNT_W-1:0]    count_o
);
  localparam logic [CNT_W-1:0] LIM_N = CNT_W'(LIM_NARROW);
  localparam logic [CNT_W-1:0] LIM_W = CNT_W'(LIM_WIDE);

  logic [1:0]       code;
  logic [CNT_W-1:0] limit;
  logic             code_ok;

  assign code    = size_i[WSEL_LSB+1:WSEL_LSB];
  assign count_o = size_i[CNT_W-1:0];

  always_comb begin
    code_ok = 1'b1;
    limit   = LIM_N;
    width_o = 3'd1;
    case (code)
      2'd3: begin width_o = 3'd1; limit = LIM_N; end
      2'd2: begin width_o = 3'd2; limit = LIM_N; end
      2'd0: begin width_o = 3'd4; limit = LIM_W; end
      default: begin width_o = 3'd0; code_ok = 1'b0; end
    endcase
  end

  assign valid_o = code_ok && (count_o <= limit);
endmodule

// File: rtl/dcs_beat_ctr.sv
module dcs_beat_ctr #(
  parameter int AW    = 32,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_mem_i,
  input  logic [AW-1:0]    mem_i,
  input  logic             ld_cnt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             beat_i,
  input  logic [2:0]       width_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             empty_o
);
  logic [AW-1:0]    mem_q, mem_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] w_cnt;

  assign w_cnt = CNT_W'(width_i);

  always_comb begin
    mem_d = mem_q;
    cnt_d = cnt_q;
    if (ld_mem_i) mem_d = mem_i;
    else if (beat_i) mem_d = mem_q + AW'(width_i);
    if (ld_cnt_i) cnt_d = cnt_i;
    else if (beat_i) cnt_d = (cnt_q > w_cnt) ? (cnt_q - w_cnt) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else begin
      mem_q <= mem_d;
      cnt_q <= cnt_d;
    end
  end

  assign mem_addr_o = mem_q;
  assign cnt_o      = cnt_q;
  assign empty_o    = (cnt_q == '0);

  p_cnt_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_i && !ld_cnt_i) |=> (cnt_o < $past(cnt_o)));
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW         = 32,
  parameter int CNT_W      = 12,
  parameter int WSEL_LSB   = 12,
  parameter int LIM_NARROW = 'h3FF,
  parameter int LIM_WIDE   = 'h7FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic                dir_i,
  input  logic [AW-1:0]       reg_dev_i,
  input  logic [AW-1:0]       reg_mem_i,
  input  logic [WSEL_LSB+1:0] reg_size_i,
  input  logic [AW-1:0]       reg_next_i,
  output logic                mrd_req_o,
  output logic [AW-1:0]       mrd_addr_o,
  input  logic                mrd_ack_i,
  input  logic [AW-1:0]       mrd_data_i,
  output logic                xfer_req_o,
  output logic [AW-1:0]       xfer_src_o,
  output logic [AW-1:0]       xfer_dst_o,
  output logic [2:0]          xfer_width_o,
  input  logic                xfer_ack_i,
  output logic [1:0]          state_o,
  output logic                done_o,
  output logic                err_o
);
  import dcs_pkg::*;

  dcs_state_e       state_q, state_d;
  logic [1:0]       idx_q, idx_d;
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [AW-1:0]    dev_q, dev_d;
  logic [AW-1:0]    next_q, next_d;
  logic [2:0]       width_q, width_d;
  logic             chain_q, chain_d;
  logic             done_q, done_d;
  logic             err_q, err_d;

  logic [WSEL_LSB+1:0] sz_word;
  logic                sz_valid;
  logic [2:0]          sz_width;
  logic [CNT_W-1:0]    sz_cnt;
  logic                ld_mem, ld_cnt, beat;
  logic [AW-1:0]       mem_src, mem_addr;
  logic [CNT_W-1:0]    cnt_unused;
  logic                empty;

  assign sz_word = (state_q == ST_IDLE) ? reg_size_i : mrd_data_i[WSEL_LSB+1:0];
  assign mem_src = (state_q == ST_IDLE) ? reg_mem_i : mrd_data_i;

  dcs_size_chk #(
    .CNT_W(CNT_W), .WSEL_LSB(WSEL_LSB),
    .LIM_NARROW(LIM_NARROW), .LIM_WIDE(LIM_WIDE)
  ) i_size_chk (
    .size_i (sz_word),
    .valid_o(sz_valid),
    .width_o(sz_width),
    .count_o(sz_cnt)
  );

  dcs_beat_ctr #(.AW(AW), .CNT_W(CNT_W)) i_beat_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_mem_i  (ld_mem),
    .mem_i     (mem_src),
    .ld_cnt_i  (ld_cnt),
    .cnt_i     (sz_cnt),
    .beat_i    (beat),
    .width_i   (width_q),
    .mem_addr_o(mem_addr),
    .cnt_o     (cnt_unused),
    .empty_o   (empty)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    dev_d   = dev_q;
    next_d  = next_q;
    width_d = width_q;
    chain_d = chain_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    ld_mem  = 1'b0;
    ld_cnt  = 1'b0;
    beat    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i && mode_i == MODE_ONCE) begin
          if (!sz_valid) begin
            err_d = 1'b1;
          end else begin
            dev_d   = reg_dev_i;
            next_d  = reg_next_i;
            width_d = sz_width;
            ld_mem  = 1'b1;
            ld_cnt  = 1'b1;
            chain_d = 1'b0;
            state_d = ST_WAIT;
          end
        end else if (start_i && mode_i == MODE_CHAIN) begin
          ptr_d   = {reg_next_i[AW-1:2], 2'b00};
          idx_d   = 2'd0;
          chain_d = 1'b1;
          state_d = ST_DESC;
        end
      end
      ST_DESC: begin
        if (mrd_ack_i) begin
          idx_d = idx_q + 2'd1;
          case (idx_q)
            2'd0: dev_d = mrd_data_i;
            2'd1: ld_mem = 1'b1;
            2'd2: begin
              if (!sz_valid) begin
                err_d   = 1'b1;
                state_d = ST_IDLE;
              end else begin
                width_d = sz_width;
                ld_cnt  = 1'b1;
              end
            end
            default: begin
              next_d  = mrd_data_i;
              state_d = ST_WAIT;
            end
          endcase
        end
      end
      ST_WAIT: begin
        if (mode_i == MODE_OFF) begin
          state_d = ST_IDLE;
        end else if (empty) begin
          done_d = next_q[0];
          if (chain_q && next_q[1]) begin
            ptr_d   = {next_q[AW-1:2], 2'b00};
            idx_d   = 2'd0;
            state_d = ST_DESC;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          state_d = ST_ACCESS;
        end
      end
      default: begin
        if (xfer_ack_i) begin
          beat    = 1'b1;
          state_d = ST_WAIT;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= 2'd0;
      ptr_q   <= '0;
      dev_q   <= '0;
      next_q  <= '0;
      width_q <= 3'd4;
      chain_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
      dev_q   <= dev_d;
      next_q  <= next_d;
      width_q <= width_d;
      chain_q <= chain_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign state_o      = state_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign mrd_req_o    = (state_q == ST_DESC);
  assign mrd_addr_o   = ptr_q + AW'({idx_q, 2'b00});
  assign xfer_req_o   = (state_q == ST_ACCESS);
  assign xfer_src_o   = dir_i ? mem_addr : dev_q;
  assign xfer_dst_o   = dir_i ? dev_q : mem_addr;
  assign xfer_width_o = width_q;

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (state_o == ST_IDLE));
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((state_o == ST_IDLE || state_o == ST_DESC) && !err_o));
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_WAIT && mode_i == MODE_OFF) |=> (state_o == ST_IDLE && !done_o));
  p_xfer_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(xfer_src_o) && $stable(xfer_dst_o)));
  p_mrd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_req_o && !mrd_ack_i) |=> (mrd_req_o && $stable(mrd_addr_o)));
  p_width_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> $onehot(xfer_width_o));
endmodule

// File: tb/test_dma_chain_seq.sv
module test_dma_chain_seq;
  logic        clk, rst_n, start, dir, ack_en;
  logic [1:0]  mode;
  logic [31:0] r_dev, r_mem, r_next;
  logic [13:0] r_size;
  logic        mrd_req, mrd_ack, xfer_req, xfer_ack, done, err;
  logic [31:0] mrd_addr, mrd_data, src, dst;
  logic [2:0]  width;
  logic [1:0]  state;
  logic [31:0] mem [0:63];

  int n_chk, n_fail, cyc;
  int beats, dones, errs;
  logic seen_desc;
  logic [31:0] first_src, last_src, last_dst;
  logic [2:0]  last_w;

  dma_chain_seq i_dma_chain_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .dir_i(dir),
    .reg_dev_i(r_dev), .reg_mem_i(r_mem), .reg_size_i(r_size), .reg_next_i(r_next),
    .mrd_req_o(mrd_req), .mrd_addr_o(mrd_addr), .mrd_ack_i(mrd_ack), .mrd_data_i(mrd_data),
    .xfer_req_o(xfer_req), .xfer_src_o(src), .xfer_dst_o(dst), .xfer_width_o(width),
    .xfer_ack_i(xfer_ack), .state_o(state), .done_o(done), .err_o(err));

  assign mrd_ack  = mrd_req;
  assign mrd_data = mem[mrd_addr[7:2]];
  assign xfer_ack = xfer_req & ack_en;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (xfer_req && xfer_ack) begin
        if (beats == 0) first_src <= src;
        last_src <= src;
        last_dst <= dst;
        last_w   <= width;
        beats    <= beats + 1;
      end
      if (done) dones <= dones + 1;
      if (err) errs <= errs + 1;
      if (state == 2'd1) seen_desc <= 1'b1;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run did not end, cycle %0d expected below 150000", cyc);
    finish_run();
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    beats = 0; dones = 0; errs = 0; seen_desc = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && state != 2'd0; i++) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic run_once(input logic d, input logic [31:0] dv, input logic [31:0] mm,
                          input logic [13:0] sz, input logic [31:0] nx);
    clear_mon();
    mode = 2'd2; dir = d; r_dev = dv; r_mem = mm; r_size = sz; r_next = nx;
    pulse_start();
    wait_idle();
  endtask

  task automatic run_chain(input logic d, input logic [31:0] ptr);
    clear_mon();
    mode = 2'd1; dir = d; r_next = ptr;
    pulse_start();
    wait_idle();
  endtask

  task automatic t_reset();
    check(state == 2'd0, "R1 state", state, 0);
    check(!mrd_req && !xfer_req, "R1 requests", {mrd_req, xfer_req}, 0);
    check(!done && !err, "R1 pulses", {done, err}, 0);
  endtask

  task automatic t_once_wide();
    run_once(1'b1, 32'h8000_0100, 32'h1000, 14'h0010, 32'h1);
    check(beats == 4, "R3 beats 4-byte", beats, 4);
    check(first_src == 32'h1000 && last_src == 32'h100C, "R3 mem step 4", last_src, 32'h100C);
    check(last_dst == 32'h8000_0100, "R4 dev fixed dir1", last_dst, 32'h8000_0100);
    check(last_w == 3'd4, "R3 width 4", last_w, 4);
    check(dones == 1 && !seen_desc, "R2 one-shot done, no fetch", dones, 1);
  endtask

  task automatic t_once_byte_rx();
    run_once(1'b0, 32'h8000_0200, 32'h2000, 14'h3003, 32'h0);
    check(beats == 3, "R3 beats 1-byte", beats, 3);
    check(last_src == 32'h8000_0200, "R4 src dev dir0", last_src, 32'h8000_0200);
    check(last_dst == 32'h2002, "R4 dst mem dir0", last_dst, 32'h2002);
    check(dones == 0, "R7 no done when bit0 clear", dones, 0);
  endtask

  task automatic t_once_ignores_follow();
    run_once(1'b1, 32'h8000_0300, 32'h2100, 14'h2006, 32'h43);
    check(beats == 3 && !seen_desc, "R6 one-shot ignores follow", beats, 3);
    check(dones == 1, "R7 done one-shot", dones, 1);
  endtask

  task automatic t_chain_a();
    mem[0] = 32'h9000_0000; mem[1] = 32'h3000; mem[2] = 32'h2004; mem[3] = 32'h12;
    mem[4] = 32'h9000_0004; mem[5] = 32'h4000; mem[6] = 32'h3002; mem[7] = 32'h1;
    run_chain(1'b1, 32'h3);
    check(seen_desc == 1'b1, "R5 descriptor read state", seen_desc, 1);
    check(beats == 4, "R6 chain total beats", beats, 4);
    check(last_src == 32'h4001 && last_dst == 32'h9000_0004, "R5 second descriptor words",
          last_src, 32'h4001);
    check(dones == 1, "R7 done only on bit0", dones, 1);
  endtask

  task automatic t_chain_b();
    mem[8]  = 32'h9000_0010; mem[9]  = 32'h5000; mem[10] = 32'h0004; mem[11] = 32'h33;
    mem[12] = 32'h9000_0014; mem[13] = 32'h5100; mem[14] = 32'h0008; mem[15] = 32'h0;
    run_chain(1'b0, 32'h20);
    check(beats == 3, "R6 follow-with-done chain beats", beats, 3);
    check(last_dst == 32'h5104 && last_src == 32'h9000_0014, "R4 chain dir0", last_dst, 32'h5104);
    check(dones == 1, "R7 done on first link only", dones, 1);
  endtask

  task automatic t_limits();
    run_once(1'b1, 32'h8000_0400, 32'h6000, 14'h1004, 32'h1);
    check(errs == 1 && beats == 0 && dones == 0, "R8 width code 1", errs, 1);
    check(state == 2'd0, "R8 idle after error", state, 0);
    run_once(1'b1, 32'h8000_0400, 32'h6000, 14'h3400, 32'h1);
    check(errs == 1 && beats == 0, "R8 1-byte over limit", errs, 1);
    run_once(1'b1, 32'h8000_0400, 32'h6000, 14'h23FF, 32'h1);
    check(errs == 0 && beats == 512, "R8 2-byte at limit", beats, 512);
    run_once(1'b1, 32'h8000_0400, 32'h6000, 14'h07FF, 32'h1);
    check(errs == 0 && beats == 512 && dones == 1, "R8 4-byte at limit", beats, 512);
    run_once(1'b1, 32'h8000_0400, 32'h6000, 14'h0800, 32'h1);
    check(errs == 1 && beats == 0, "R8 4-byte over limit", errs, 1);
    mem[16] = 32'h9000_0020; mem[17] = 32'h7000; mem[18] = 32'h1008; mem[19] = 32'h1;
    run_chain(1'b1, 32'h40);
    check(errs == 1 && beats == 0 && state == 2'd0, "R8 chain bad size", errs, 1);
  endtask

  task automatic t_busy_start();
    clear_mon();
    ack_en = 1'b0;
    mode = 2'd2; dir = 1'b1; r_dev = 32'h8000_0500; r_mem = 32'h5000; r_size = 14'h0008; r_next = 32'h1;
    pulse_start();
    repeat (4) @(negedge clk);
    r_mem = 32'h6000; r_size = 14'h0028;
    pulse_start();
    repeat (2) @(negedge clk);
    ack_en = 1'b1;
    wait_idle();
    check(beats == 2 && first_src == 32'h5000, "R9 busy start ignored", beats, 2);
    check(dones == 1, "R9 single completion", dones, 1);
  endtask

  task automatic t_abort();
    clear_mon();
    ack_en = 1'b0;
    mode = 2'd2; dir = 1'b1; r_dev = 32'h8000_0600; r_mem = 32'h7000; r_size = 14'h0010; r_next = 32'h1;
    pulse_start();
    repeat (4) @(negedge clk);
    mode = 2'd0;
    @(negedge clk);
    ack_en = 1'b1;
    wait_idle();
    check(beats == 1, "R10 abort after pending beat", beats, 1);
    check(dones == 0 && state == 2'd0, "R10 no done on abort", dones, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    beats = 0; dones = 0; errs = 0; seen_desc = 1'b0;
    first_src = '0; last_src = '0; last_dst = '0; last_w = '0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    rst_n = 1'b0; start = 1'b0; mode = 2'd0; dir = 1'b0; ack_en = 1'b1;
    r_dev = '0; r_mem = '0; r_size = '0; r_next = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_once_wide();
    t_once_byte_rx();
    t_once_ignores_follow();
    t_chain_a();
    t_chain_b();
    t_limits();
    t_busy_start();
    t_abort();
    finish_run();
  end
endmodule